// File: doc/BRIEF.md
# Coherent Byte-Read Latch for a 16-bit Capture Value

This block holds a 16-bit channel value and presents it to an 8-bit bus so that software, which must read the value as two separate bytes, always obtains a high and a low byte taken at the same instant. The value register is loaded as a whole by the capture logic or one byte at a time by bus writes. The read data is combinational on the cycle of the read strobe.

In capture mode, software may start with either byte. The first byte read copies the whole value into a holding buffer and freezes it. Later reads of either byte return the buffered data until the opposite byte has been read. A write to the channel's control register also ends the freeze at once, as does leaving capture mode. Outside capture mode no freeze ever forms and reads return the live value.

Top module: `cbr_coherent_read`

## Requirements
- R1: After reset, the value register and the holding buffer are zero, no freeze is active, and reads of either byte return 0x00.
- R2: A high-byte write sets bits 15..8 and a low-byte write sets bits 7..0 of the value at the next clock edge. A capture load replaces every half not written by a byte write in the same cycle.
- R3: While capture mode is off, a read returns the live byte of the value in the same cycle and never starts a freeze.
- R4: In capture mode, with no freeze active, a high-byte read returns the live high byte and freezes all 16 bits. A following low-byte read returns the low byte from that instant, even if the value has changed since.
- R5: In capture mode, a low-byte read may start the freeze. A following high-byte read then returns the high byte taken at the low-byte read.
- R6: Reading the byte that started the freeze again returns the buffered byte and keeps the freeze.
- R7: Reading the opposite byte ends the freeze. The read after that returns live data.
- R8: A control-register write ends any freeze. A read in the same cycle still returns the data that applies in that cycle, and that read starts no new freeze.
- R9: Clearing capture mode ends any freeze.
- R10: When both read strobes are active in one cycle, the block treats the cycle as a high-byte read only.
- R11: With no read strobe active, the read data is 0x00.
- R12: A byte write or capture load during a freeze changes the value register but not the buffered data that reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_mode | input | 1 | Channel is configured for input capture |
| ctrl_wr | input | 1 | Write strobe of the channel control register |
| rd_hi | input | 1 | Read strobe for bits 15..8 |
| rd_lo | input | 1 | Read strobe for bits 7..0 |
| wr_hi | input | 1 | Write strobe for bits 15..8 |
| wr_lo | input | 1 | Write strobe for bits 7..0 |
| wr_data | input | 8 | Byte write data |
| load_en | input | 1 | Capture load of the full value |
| load_val | input | 16 | Value loaded by the capture logic |
| rd_data | output | 8 | Read data, valid in the cycle of the strobe |
| value | output | 16 | Current value register |

## Verification
The read path is tried with high-first and low-first pairs, repeated reads of the same byte, and dual strobes. Each of these runs with a capture load between the two reads, so frozen data and live data differ and a read from the wrong source shows up. Releases are tried by opposite-byte read, control write (alone and together with a read) and leaving capture mode. A fresh load after each release shows whether the freeze really ended. Byte writes during a freeze separate the value register from the buffer.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    // Which byte opened the current freeze, if any.
    typedef enum logic [1:0] {
        HOLD_FREE  = 2'd0,
        HOLD_BY_HI = 2'd1,
        HOLD_BY_LO = 2'd2
    } hold_state_e;

    // Effective read request after resolving simultaneous strobes.
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_HIGH = 2'd1,
        RD_LOW  = 2'd2
    } rd_sel_e;

    function automatic rd_sel_e resolve_read(input logic hi, input logic lo);
        if (hi)      return RD_HIGH;
        else if (lo) return RD_LOW;
        else         return RD_NONE;
    endfunction

endpackage

// File: rtl/cbr_value_reg.sv
module cbr_value_reg #(
    parameter int BYTE_W = 8,
    localparam int DATA_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] value_q
);
    // Lane 0 is the low half, lane 1 the high half.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_d;
        logic [BYTE_W-1:0] lane_q;
        logic              lane_wr;

        assign lane_wr = (g == 1) ? wr_hi : wr_lo;

        always_comb begin
            lane_d = lane_q;
            if (lane_wr)
                lane_d = wr_data;
            else if (load_en)
                lane_d = load_val[g*BYTE_W +: BYTE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end

        assign value_q[g*BYTE_W +: BYTE_W] = lane_q;
    end
endmodule

// File: rtl/cbr_hold_ctrl.sv
module cbr_hold_ctrl
    import cbr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DATA_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_mode,
    input  logic              ctrl_wr,
    input  rd_sel_e           rd_sel,
    input  logic [DATA_W-1:0] value_q,
    output logic              held,
    output logic [DATA_W-1:0] hold_buf
);
    typedef struct packed {
        hold_state_e       st;
        logic [DATA_W-1:0] buff;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (ctrl_wr || !cap_mode) begin
            hold_d.st = HOLD_FREE;
        end else begin
            unique case (hold_q.st)
                HOLD_FREE: begin
                    if (rd_sel == RD_HIGH) begin
                        hold_d.st   = HOLD_BY_HI;
                        hold_d.buff = value_q;
                    end else if (rd_sel == RD_LOW) begin
                        hold_d.st   = HOLD_BY_LO;
                        hold_d.buff = value_q;
                    end
                end
                HOLD_BY_HI: if (rd_sel == RD_LOW)  hold_d.st = HOLD_FREE;
                HOLD_BY_LO: if (rd_sel == RD_HIGH) hold_d.st = HOLD_FREE;
                default:    hold_d.st = HOLD_FREE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.st   <= HOLD_FREE;
            hold_q.buff <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign held     = (hold_q.st != HOLD_FREE);
    assign hold_buf = hold_q.buff;
endmodule

// File: rtl/cbr_read_mux.sv
module cbr_read_mux
    import cbr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DATA_W = 2 * BYTE_W
) (
    input  rd_sel_e           rd_sel,
    input  logic              held,
    input  logic [DATA_W-1:0] hold_buf,
    input  logic [DATA_W-1:0] value_q,
    output logic [BYTE_W-1:0] rd_data
);
    logic [DATA_W-1:0] src;

    always_comb begin
        src = held ? hold_buf : value_q;
        unique case (rd_sel)
            RD_HIGH: rd_data = src[DATA_W-1:BYTE_W];
            RD_LOW:  rd_data = src[BYTE_W-1:0];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cbr_coherent_read.sv
module cbr_coherent_read
    import cbr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DATA_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_mode,
    input  logic              ctrl_wr,
    input  logic              rd_hi,
    input  logic              rd_lo,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [BYTE_W-1:0] rd_data,
    output logic [DATA_W-1:0] value
);
    rd_sel_e           rd_sel;
    logic              held_w;
    logic [DATA_W-1:0] hold_buf_w;
    logic [DATA_W-1:0] value_w;

    assign rd_sel = resolve_read(rd_hi, rd_lo);

    cbr_value_reg #(.BYTE_W(BYTE_W)) u_value (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wr_data  (wr_data),
        .load_en  (load_en),
        .load_val (load_val),
        .value_q  (value_w)
    );

    cbr_hold_ctrl #(.BYTE_W(BYTE_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_mode (cap_mode),
        .ctrl_wr  (ctrl_wr),
        .rd_sel   (rd_sel),
        .value_q  (value_w),
        .held     (held_w),
        .hold_buf (hold_buf_w)
    );

    cbr_read_mux #(.BYTE_W(BYTE_W)) u_mux (
        .rd_sel   (rd_sel),
        .held     (held_w),
        .hold_buf (hold_buf_w),
        .value_q  (value_w),
        .rd_data  (rd_data)
    );

    assign value = value_w;
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
    parameter int BYTE_W = 8,
    localparam int DATA_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_mode,
    input logic              ctrl_wr,
    input logic              rd_hi,
    input logic              rd_lo,
    input logic [BYTE_W-1:0] rd_data,
    input logic [DATA_W-1:0] value,
    input logic              held,
    input logic [DATA_W-1:0] hold_buf
);
    // R11: no strobe, no data
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hi && !rd_lo) |-> (rd_data == '0));

    // R3: live high byte returned when nothing is frozen
    p_live_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && rd_hi) |-> (rd_data == value[DATA_W-1:BYTE_W]));

    // R9: capture mode off leaves no freeze behind
    p_mode_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_mode |=> !held);

    // R8: control write ends the freeze
    p_ctrl_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !held);

    // R4: a read in capture mode with nothing frozen opens a freeze
    p_freeze_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && cap_mode && !ctrl_wr && (rd_hi || rd_lo)) |=> held);

    // R12: buffer does not move while a freeze persists
    p_buf_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (!held || $stable(hold_buf)));
endmodule

bind cbr_coherent_read cbr_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_mode (cap_mode),
    .ctrl_wr  (ctrl_wr),
    .rd_hi    (rd_hi),
    .rd_lo    (rd_lo),
    .rd_data  (rd_data),
    .value    (value),
    .held     (held_w),
    .hold_buf (hold_buf_w)
);

// File: tb/tb_cbr_coherent_read.sv
module tb_cbr_coherent_read;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_mode = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic        rd_hi = 1'b0;
    logic        rd_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic        wr_lo = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        load_en = 1'b0;
    logic [15:0] load_val = '0;
    logic [7:0]  rd_data;
    logic [15:0] value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cbr_coherent_read dut (
        .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode), .ctrl_wr(ctrl_wr),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .load_en(load_en), .load_val(load_val),
        .rd_data(rd_data), .value(value)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, sample, then clear after the rising edge.
    task automatic rd(input bit hi, input bit lo, input bit cw, output logic [7:0] d);
        @(negedge clk);
        rd_hi = hi; rd_lo = lo; ctrl_wr = cw;
        #1 d = rd_data;
        @(posedge clk); #1;
        rd_hi = 0; rd_lo = 0; ctrl_wr = 0;
    endtask

    task automatic load(input logic [15:0] v);
        @(negedge clk);
        load_en = 1; load_val = v;
        @(posedge clk); #1;
        load_en = 0;
    endtask

    task automatic wbyte(input bit hi, input logic [7:0] d);
        @(negedge clk);
        wr_hi = hi; wr_lo = !hi; wr_data = d;
        @(posedge clk); #1;
        wr_hi = 0; wr_lo = 0;
    endtask

    task automatic ctrl_pulse();
        logic [7:0] d;
        rd(0, 0, 1, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk); #1;
        chk("R1 value", value, 16'h0000);
        chk("R11 idle", {8'h0, rd_data}, 16'h0000);
        cap_mode = 1;
        rd(1, 0, 0, d); chk("R1 hi", {8'h0, d}, 16'h0000);
        rd(0, 1, 0, d); chk("R1 lo", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_writes();
        wbyte(1, 8'hA5); chk("R2 hi write", value, 16'hA500);
        wbyte(0, 8'h3C); chk("R2 lo write", value, 16'hA53C);
        load(16'h1234); chk("R2 load", value, 16'h1234);
        @(negedge clk);
        load_en = 1; load_val = 16'hFFFF; wr_hi = 1; wr_data = 8'h77;
        @(posedge clk); #1;
        load_en = 0; wr_hi = 0;
        chk("R2 write over load", value, 16'h77FF);
    endtask

    task automatic t_no_capture();
        logic [7:0] d;
        cap_mode = 0;
        load(16'h1111);
        rd(1, 0, 0, d); chk("R3 hi", {8'h0, d}, 16'h0011);
        load(16'h2222);
        rd(0, 1, 0, d); chk("R3 lo live", {8'h0, d}, 16'h0022);
        rd(1, 0, 0, d); chk("R3 hi live", {8'h0, d}, 16'h0022);
        @(negedge clk); #1;
        chk("R11 idle", {8'h0, rd_data}, 16'h0000);
    endtask

    task automatic t_hi_first();
        logic [7:0] d;
        cap_mode = 1;
        load(16'hABCD);
        rd(1, 0, 0, d); chk("R4 hi first", {8'h0, d}, 16'h00AB);
        load(16'h5566);
        rd(0, 1, 0, d); chk("R4 lo frozen", {8'h0, d}, 16'h00CD);
        rd(1, 0, 0, d); chk("R7 released hi", {8'h0, d}, 16'h0055);
        rd(0, 1, 0, d); chk("R7 pair lo", {8'h0, d}, 16'h0066);
    endtask

    task automatic t_lo_first();
        logic [7:0] d;
        load(16'h0102);
        rd(0, 1, 0, d); chk("R5 lo first", {8'h0, d}, 16'h0002);
        load(16'h0304);
        rd(0, 1, 0, d); chk("R6 repeat lo", {8'h0, d}, 16'h0002);
        rd(1, 0, 0, d); chk("R5 hi frozen", {8'h0, d}, 16'h0001);
        rd(0, 1, 0, d); chk("R7 released lo", {8'h0, d}, 16'h0004);
        ctrl_pulse();
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        load(16'h1357);
        rd(1, 0, 0, d); chk("R4 hi", {8'h0, d}, 16'h0013);
        load(16'h2468);
        ctrl_pulse();
        rd(0, 1, 0, d); chk("R8 after ctrl", {8'h0, d}, 16'h0068);
        load(16'h9ABC);
        rd(1, 0, 1, d); chk("R8 read with ctrl", {8'h0, d}, 16'h0024);
        rd(0, 1, 0, d); chk("R8 no new freeze", {8'h0, d}, 16'h00BC);
        ctrl_pulse();
    endtask

    task automatic t_mode_exit();
        logic [7:0] d;
        load(16'h4444);
        rd(1, 0, 0, d); chk("R4 hi", {8'h0, d}, 16'h0044);
        @(negedge clk); cap_mode = 0;
        @(negedge clk); cap_mode = 1;
        load(16'h5A55);
        rd(0, 1, 0, d); chk("R9 mode exit", {8'h0, d}, 16'h0055);
        ctrl_pulse();
    endtask

    task automatic t_dual();
        logic [7:0] d;
        load(16'h6A6B);
        rd(1, 1, 0, d); chk("R10 dual", {8'h0, d}, 16'h006A);
        load(16'h7C7D);
        rd(1, 0, 0, d); chk("R10 held by hi", {8'h0, d}, 16'h006A);
        rd(0, 1, 0, d); chk("R10 lo releases", {8'h0, d}, 16'h006B);
        rd(1, 0, 0, d); chk("R10 live after", {8'h0, d}, 16'h007C);
        ctrl_pulse();
    endtask

    task automatic t_write_frozen();
        logic [7:0] d;
        load(16'h0F0F);
        rd(1, 0, 0, d); chk("R4 hi", {8'h0, d}, 16'h000F);
        wbyte(0, 8'hEE);
        chk("R12 value moved", value, 16'h0FEE);
        rd(0, 1, 0, d); chk("R12 lo frozen", {8'h0, d}, 16'h000F);
        rd(0, 1, 0, d); chk("R12 lo live", {8'h0, d}, 16'h00EE);
        ctrl_pulse();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_writes();
        t_no_capture();
        t_hi_first();
        t_lo_first();
        t_ctrl();
        t_mode_exit();
        t_dual();
        t_write_frozen();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule